// File: doc/BRIEF.md
# Narrow-to-Wide Pair Merging Bridge

The bridge sits between a 32-bit AXI4-Lite master and a 64-bit AXI4 memory-mapped slave. The slave answers only at one base address and accepts only INCR bursts. The master can only issue single-beat accesses, so a 64-bit quantity reaches the bridge as two consecutive 32-bit accesses: the low word at the base address, then the high word at base+4. The bridge turns each such pair into a single 64-bit access at the base address. No access at base+4 ever reaches the slave.

Writes work as follows. A low-word write is parked inside the bridge together with its byte strobes, and it is acknowledged at once. The following high-word write releases both halves as one 64-bit beat. The slave's write response is then handed back as the answer to the high-word write.

Reads work the other way round. A low-word read fetches the whole 64-bit word from the slave. The bridge returns the low half and keeps the high half, so that the next read at base+4 is served locally. Only one upstream transaction is in flight at a time, and a write wins over a read that is presented in the same cycle.

Top module: `wide_merge_bridge`

## Requirements
- R1: A write at BASE_ADDR stores the data and strobes, answers OKAY (2'b00) on the upstream B channel, and issues nothing downstream.
- R2: A write at BASE_ADDR+4 while a low word is parked issues exactly one downstream write with address BASE_ADDR, length 0, size 3, burst 2'b01 (INCR) and last set. It carries data {high, low} and strobes {high strobes, low strobes}.
- R3: The downstream write response is returned upstream as the response to the high-word write, and the parked low word is consumed by it.
- R4: A write at BASE_ADDR+4 with no parked low word answers SLVERR (2'b10) and issues nothing downstream.
- R5: A second write at BASE_ADDR replaces the parked low word and strobes.
- R6: A read at BASE_ADDR issues one downstream read with address BASE_ADDR, length 0, size 3 and burst 2'b01. It returns bits [31:0] of the slave data with the slave's read response.
- R7: A read at BASE_ADDR+4 while a high half is held returns bits [63:32] of the last fetched word with its response. It makes no downstream access and releases the held half.
- R8: A read at BASE_ADDR+4 with no held high half answers SLVERR with data 0 and makes no downstream access.
- R9: At most one transaction is active at a time. When a write (address and data) and a read are presented together, the write is accepted first.
- R10: Every VALID the bridge drives, upstream or downstream, stays asserted with stable payload until its handshake completes.
- R11: Reset clears the parked low word, the held high half and every VALID the bridge drives.
- R12: An access whose address is neither BASE_ADDR nor BASE_ADDR+4 (word aligned) answers SLVERR with read data 0 and makes no downstream access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_awaddr | input | ADDR_W | Upstream write address |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_wdata | input | 32 | Upstream write data |
| s_wstrb | input | 4 | Upstream write strobes |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_bresp | output | 2 | Upstream write response |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_araddr | input | ADDR_W | Upstream read address |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_rdata | output | 32 | Upstream read data |
| s_rresp | output | 2 | Upstream read response |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| m_awaddr | output | ADDR_W | Downstream write address |
| m_awlen | output | 8 | Downstream write burst length |
| m_awsize | output | 3 | Downstream write beat size |
| m_awburst | output | 2 | Downstream write burst type |
| m_awvalid | output | 1 | Downstream write address valid |
| m_awready | input | 1 | Downstream write address ready |
| m_wdata | output | 64 | Downstream write data |
| m_wstrb | output | 8 | Downstream write strobes |
| m_wlast | output | 1 | Downstream last write beat |
| m_wvalid | output | 1 | Downstream write data valid |
| m_wready | input | 1 | Downstream write data ready |
| m_bresp | input | 2 | Downstream write response |
| m_bvalid | input | 1 | Downstream write response valid |
| m_bready | output | 1 | Downstream write response ready |
| m_araddr | output | ADDR_W | Downstream read address |
| m_arlen | output | 8 | Downstream read burst length |
| m_arsize | output | 3 | Downstream read beat size |
| m_arburst | output | 2 | Downstream read burst type |
| m_arvalid | output | 1 | Downstream read address valid |
| m_arready | input | 1 | Downstream read address ready |
| m_rdata | input | 64 | Downstream read data |
| m_rresp | input | 2 | Downstream read response |
| m_rvalid | input | 1 | Downstream read data valid |
| m_rready | output | 1 | Downstream read data ready |

## Verification
On every cycle the assertions check the following:
- VALID is held, with its payload stable, until the handshake completes.
- No two transactions are active together.
- A low-word write is answered locally with OKAY and never opens a downstream write.
- A read at the high word or outside the window is answered without touching the downstream read channel.
- A low-word read does reach the downstream read channel.

Some behaviour depends on data carried across several transactions, and only the bench's directed scenarios can show it. This covers the merged data and strobe layout, the replacement of a parked word, the consumption of the held halves, the pass-through of slave error responses, write-over-read ordering and the clearing of state by reset.

// File: rtl/wmb_pkg.sv
package wmb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_B,
    ST_DN_WR,
    ST_DN_B,
    ST_DN_AR,
    ST_DN_R,
    ST_UP_R
  } wmb_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] BURST_INCR  = 2'b01;

endpackage

// File: rtl/wmb_ctrl.sv
module wmb_ctrl
  import wmb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int unsigned HI_BIT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  input  logic              s_wvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  input  logic              s_rready,
  input  logic              pend_valid,
  input  logic              m_awready,
  input  logic              m_wready,
  input  logic              m_bvalid,
  input  logic              m_arready,
  input  logic              m_rvalid,
  output logic              s_awready,
  output logic              s_wready,
  output logic              s_bvalid,
  output logic              s_arready,
  output logic              s_rvalid,
  output logic              m_awvalid,
  output logic              m_wvalid,
  output logic              m_bready,
  output logic              m_arvalid,
  output logic              m_rready,
  output logic              wr_lo_ld,
  output logic              wr_hi_acc,
  output logic              wr_bad,
  output logic              wr_b_ld,
  output logic              rd_lo_ld,
  output logic              rd_hi_acc,
  output logic              rd_bad
);

  localparam int unsigned TAG_LSB = HI_BIT + 1;

  wmb_state_e st_q, st_d;
  logic       aw_done_q, aw_done_d;
  logic       w_done_q, w_done_d;

  logic idle, wr_go, wr_acc, rd_acc;
  logic aw_ok, aw_hi, ar_ok, ar_hi;
  logic aw_fire, w_fire;

  // window decode: tag bits match the base and the sub-word bits are zero
  always_comb begin
    aw_ok = (s_awaddr[ADDR_W-1:TAG_LSB] == BASE_ADDR[ADDR_W-1:TAG_LSB]) &&
            (s_awaddr[HI_BIT-1:0] == '0);
    ar_ok = (s_araddr[ADDR_W-1:TAG_LSB] == BASE_ADDR[ADDR_W-1:TAG_LSB]) &&
            (s_araddr[HI_BIT-1:0] == '0);
    aw_hi = s_awaddr[HI_BIT];
    ar_hi = s_araddr[HI_BIT];
  end

  always_comb begin
    idle      = (st_q == ST_IDLE);
    wr_go     = s_awvalid && s_wvalid;
    wr_acc    = idle && wr_go;
    rd_acc    = idle && !wr_go && s_arvalid;

    s_awready = wr_acc;
    s_wready  = wr_acc;
    s_arready = idle && !wr_go;
    s_bvalid  = (st_q == ST_UP_B);
    s_rvalid  = (st_q == ST_UP_R);
    m_awvalid = (st_q == ST_DN_WR) && !aw_done_q;
    m_wvalid  = (st_q == ST_DN_WR) && !w_done_q;
    m_bready  = (st_q == ST_DN_B);
    m_arvalid = (st_q == ST_DN_AR);
    m_rready  = (st_q == ST_DN_R);

    aw_fire   = m_awvalid && m_awready;
    w_fire    = m_wvalid && m_wready;

    wr_lo_ld  = wr_acc && aw_ok && !aw_hi;
    wr_hi_acc = wr_acc && aw_ok && aw_hi;
    wr_bad    = wr_acc && !aw_ok;
    wr_b_ld   = (st_q == ST_DN_B) && m_bvalid;
    rd_lo_ld  = (st_q == ST_DN_R) && m_rvalid;
    rd_hi_acc = rd_acc && ar_ok && ar_hi;
    rd_bad    = rd_acc && !ar_ok;
  end

  // next-state logic
  always_comb begin
    st_d      = st_q;
    aw_done_d = aw_done_q;
    w_done_d  = w_done_q;
    unique case (st_q)
      ST_IDLE: begin
        aw_done_d = 1'b0;
        w_done_d  = 1'b0;
        if (wr_hi_acc && pend_valid) begin
          st_d = ST_DN_WR;
        end else if (wr_acc) begin
          st_d = ST_UP_B;
        end else if (rd_acc) begin
          st_d = (ar_ok && !ar_hi) ? ST_DN_AR : ST_UP_R;
        end
      end
      ST_DN_WR: begin
        if (aw_fire) aw_done_d = 1'b1;
        if (w_fire)  w_done_d  = 1'b1;
        if ((aw_done_q || aw_fire) && (w_done_q || w_fire)) begin
          st_d = ST_DN_B;
        end
      end
      ST_DN_B:  if (m_bvalid)  st_d = ST_UP_B;
      ST_UP_B:  if (s_bready)  st_d = ST_IDLE;
      ST_DN_AR: if (m_arready) st_d = ST_DN_R;
      ST_DN_R:  if (m_rvalid)  st_d = ST_UP_R;
      ST_UP_R:  if (s_rready)  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
    end else begin
      st_q      <= st_d;
      aw_done_q <= aw_done_d;
      w_done_q  <= w_done_d;
    end
  end

endmodule

// File: rtl/wmb_write_hold.sv
module wmb_write_hold
  import wmb_pkg::*;
#(
  parameter int unsigned S_DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo_ld,
  input  logic                  wr_hi_acc,
  input  logic                  wr_bad,
  input  logic                  wr_b_ld,
  input  logic [S_DW-1:0]       s_wdata,
  input  logic [S_DW/8-1:0]     s_wstrb,
  input  logic [1:0]            m_bresp,
  output logic                  pend_valid,
  output logic [2*S_DW-1:0]     m_wdata,
  output logic [2*S_DW/8-1:0]   m_wstrb,
  output logic [1:0]            s_bresp
);

  localparam int unsigned SB = S_DW / 8;

  logic              pend_q, pend_d;
  logic [S_DW-1:0]   lo_data_q;
  logic [SB-1:0]     lo_strb_q;
  logic              lo_en;
  logic              beat_en;
  logic [2*S_DW-1:0] beat_data_q;
  logic [2*SB-1:0]   beat_strb_q;
  logic              resp_en;
  logic [1:0]        resp_d, resp_q;

  always_comb begin
    lo_en   = wr_lo_ld;
    beat_en = wr_hi_acc && pend_q;

    pend_d = pend_q;
    if (wr_lo_ld)       pend_d = 1'b1;
    else if (wr_hi_acc) pend_d = 1'b0;

    resp_en = wr_lo_ld || wr_bad || (wr_hi_acc && !pend_q) || wr_b_ld;
    resp_d  = RESP_OKAY;
    if (wr_b_ld)                              resp_d = m_bresp;
    else if (wr_bad || (wr_hi_acc && !pend_q)) resp_d = RESP_SLVERR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      resp_q <= RESP_OKAY;
    end else begin
      pend_q <= pend_d;
      if (resp_en) resp_q <= resp_d;
    end
  end

  // datapath registers: no reset needed, qualified by valid flags
  always_ff @(posedge clk) begin
    if (lo_en) begin
      lo_data_q <= s_wdata;
      lo_strb_q <= s_wstrb;
    end
    if (beat_en) begin
      beat_data_q <= {s_wdata, lo_data_q};
      beat_strb_q <= {s_wstrb, lo_strb_q};
    end
  end

  assign pend_valid = pend_q;
  assign m_wdata    = beat_data_q;
  assign m_wstrb    = beat_strb_q;
  assign s_bresp    = resp_q;

endmodule

// File: rtl/wmb_read_hold.sv
module wmb_read_hold
  import wmb_pkg::*;
#(
  parameter int unsigned S_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_lo_ld,
  input  logic              rd_hi_acc,
  input  logic              rd_bad,
  input  logic [2*S_DW-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  output logic [S_DW-1:0]   s_rdata,
  output logic [1:0]        s_rresp
);

  logic            hi_vld_q, hi_vld_d;
  logic [S_DW-1:0] hi_data_q;
  logic [1:0]      hi_resp_q;
  logic            out_en;
  logic [S_DW-1:0] out_data_d, out_data_q;
  logic [1:0]      out_resp_d, out_resp_q;

  always_comb begin
    hi_vld_d = hi_vld_q;
    if (rd_lo_ld)       hi_vld_d = 1'b1;
    else if (rd_hi_acc) hi_vld_d = 1'b0;

    out_en     = rd_lo_ld || rd_hi_acc || rd_bad;
    out_data_d = '0;
    out_resp_d = RESP_SLVERR;
    if (rd_lo_ld) begin
      out_data_d = m_rdata[S_DW-1:0];
      out_resp_d = m_rresp;
    end else if (rd_hi_acc && hi_vld_q) begin
      out_data_d = hi_data_q;
      out_resp_d = hi_resp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_vld_q   <= 1'b0;
      out_data_q <= '0;
      out_resp_q <= RESP_OKAY;
    end else begin
      hi_vld_q <= hi_vld_d;
      if (out_en) begin
        out_data_q <= out_data_d;
        out_resp_q <= out_resp_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_lo_ld) begin
      hi_data_q <= m_rdata[2*S_DW-1:S_DW];
      hi_resp_q <= m_rresp;
    end
  end

  assign s_rdata = out_data_q;
  assign s_rresp = out_resp_q;

endmodule

// File: rtl/wide_merge_bridge.sv
module wide_merge_bridge
  import wmb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned S_DW      = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     s_awaddr,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [S_DW-1:0]       s_wdata,
  input  logic [S_DW/8-1:0]     s_wstrb,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  input  logic [ADDR_W-1:0]     s_araddr,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  output logic [S_DW-1:0]       s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic [ADDR_W-1:0]     m_awaddr,
  output logic [7:0]            m_awlen,
  output logic [2:0]            m_awsize,
  output logic [1:0]            m_awburst,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [2*S_DW-1:0]     m_wdata,
  output logic [2*S_DW/8-1:0]   m_wstrb,
  output logic                  m_wlast,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  input  logic [1:0]            m_bresp,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  output logic [ADDR_W-1:0]     m_araddr,
  output logic [7:0]            m_arlen,
  output logic [2:0]            m_arsize,
  output logic [1:0]            m_arburst,
  output logic                  m_arvalid,
  input  logic                  m_arready,
  input  logic [2*S_DW-1:0]     m_rdata,
  input  logic [1:0]            m_rresp,
  input  logic                  m_rvalid,
  output logic                  m_rready
);

  localparam int unsigned HI_BIT  = $clog2(S_DW / 8);
  localparam logic [2:0]  WIDE_SZ = 3'($clog2(2 * S_DW / 8));

  logic pend_valid;
  logic wr_lo_ld, wr_hi_acc, wr_bad, wr_b_ld;
  logic rd_lo_ld, rd_hi_acc, rd_bad;

  // the wide beat always targets the base, single beat, incrementing
  assign m_awaddr  = BASE_ADDR;
  assign m_awlen   = 8'd0;
  assign m_awsize  = WIDE_SZ;
  assign m_awburst = BURST_INCR;
  assign m_wlast   = 1'b1;
  assign m_araddr  = BASE_ADDR;
  assign m_arlen   = 8'd0;
  assign m_arsize  = WIDE_SZ;
  assign m_arburst = BURST_INCR;

  wmb_ctrl #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .HI_BIT    (HI_BIT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_awaddr   (s_awaddr),
    .s_awvalid  (s_awvalid),
    .s_wvalid   (s_wvalid),
    .s_bready   (s_bready),
    .s_araddr   (s_araddr),
    .s_arvalid  (s_arvalid),
    .s_rready   (s_rready),
    .pend_valid (pend_valid),
    .m_awready  (m_awready),
    .m_wready   (m_wready),
    .m_bvalid   (m_bvalid),
    .m_arready  (m_arready),
    .m_rvalid   (m_rvalid),
    .s_awready  (s_awready),
    .s_wready   (s_wready),
    .s_bvalid   (s_bvalid),
    .s_arready  (s_arready),
    .s_rvalid   (s_rvalid),
    .m_awvalid  (m_awvalid),
    .m_wvalid   (m_wvalid),
    .m_bready   (m_bready),
    .m_arvalid  (m_arvalid),
    .m_rready   (m_rready),
    .wr_lo_ld   (wr_lo_ld),
    .wr_hi_acc  (wr_hi_acc),
    .wr_bad     (wr_bad),
    .wr_b_ld    (wr_b_ld),
    .rd_lo_ld   (rd_lo_ld),
    .rd_hi_acc  (rd_hi_acc),
    .rd_bad     (rd_bad)
  );

  wmb_write_hold #(.S_DW(S_DW)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lo_ld   (wr_lo_ld),
    .wr_hi_acc  (wr_hi_acc),
    .wr_bad     (wr_bad),
    .wr_b_ld    (wr_b_ld),
    .s_wdata    (s_wdata),
    .s_wstrb    (s_wstrb),
    .m_bresp    (m_bresp),
    .pend_valid (pend_valid),
    .m_wdata    (m_wdata),
    .m_wstrb    (m_wstrb),
    .s_bresp    (s_bresp)
  );

  wmb_read_hold #(.S_DW(S_DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_lo_ld  (rd_lo_ld),
    .rd_hi_acc (rd_hi_acc),
    .rd_bad    (rd_bad),
    .m_rdata   (m_rdata),
    .m_rresp   (m_rresp),
    .s_rdata   (s_rdata),
    .s_rresp   (s_rresp)
  );

endmodule

// File: rtl/wmb_checker.sv
module wmb_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned S_DW      = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] s_awaddr,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic [1:0]        s_bresp,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [ADDR_W-1:0] s_araddr,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic [S_DW-1:0]   s_rdata,
  input logic [1:0]        s_rresp,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_arvalid,
  input logic              m_arready
);

  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(S_DW / 8);

  logic aw_lo_fire, ar_lo_fire, ar_local_fire;
  assign aw_lo_fire    = s_awvalid && s_awready && (s_awaddr == BASE_ADDR);
  assign ar_lo_fire    = s_arvalid && s_arready && (s_araddr == BASE_ADDR);
  assign ar_local_fire = s_arvalid && s_arready && (s_araddr != BASE_ADDR);

  assert_lo_write_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
    aw_lo_fire |=> (s_bvalid && (s_bresp == 2'b00) && !m_awvalid && !m_wvalid));

  assert_lo_read_forwarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ar_lo_fire |=> (m_arvalid && !s_rvalid));

  // R7, R8 and R12: high-word and out-of-window reads never use the downstream read channel
  assert_local_read_no_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ar_local_fire |=> (s_rvalid && !m_arvalid));

  assert_bad_read_slverr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (s_arvalid && s_arready && (s_araddr != BASE_ADDR) && (s_araddr != HI_ADDR))
      |=> (s_rresp == 2'b10 && s_rdata == '0));

  assert_single_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s_bvalid, s_rvalid, (m_awvalid || m_wvalid), m_arvalid}));

  assert_aw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> m_awvalid);

  assert_w_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> m_wvalid);

  assert_ar_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> m_arvalid);

  assert_b_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

  assert_r_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));

endmodule

bind wide_merge_bridge wmb_checker #(
  .ADDR_W    (ADDR_W),
  .S_DW      (S_DW),
  .BASE_ADDR (BASE_ADDR)
) u_wmb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_awaddr  (s_awaddr),
  .s_awvalid (s_awvalid),
  .s_awready (s_awready),
  .s_bresp   (s_bresp),
  .s_bvalid  (s_bvalid),
  .s_bready  (s_bready),
  .s_araddr  (s_araddr),
  .s_arvalid (s_arvalid),
  .s_arready (s_arready),
  .s_rdata   (s_rdata),
  .s_rresp   (s_rresp),
  .s_rvalid  (s_rvalid),
  .s_rready  (s_rready),
  .m_awvalid (m_awvalid),
  .m_awready (m_awready),
  .m_wvalid  (m_wvalid),
  .m_wready  (m_wready),
  .m_arvalid (m_arvalid),
  .m_arready (m_arready)
);

// File: tb/tb_wide_merge_bridge.sv
`timescale 1ns/1ps
module tb_wide_merge_bridge;

  localparam logic [31:0] BASE = 32'h4000_0100;
  localparam logic [31:0] HIA  = BASE + 32'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] s_awaddr = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b0;
  logic [31:0] s_araddr = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b0;
  logic [31:0] m_awaddr;
  logic [7:0]  m_awlen;
  logic [2:0]  m_awsize;
  logic [1:0]  m_awburst;
  logic        m_awvalid;
  logic        m_awready;
  logic [63:0] m_wdata;
  logic [7:0]  m_wstrb;
  logic        m_wlast;
  logic        m_wvalid;
  logic        m_wready;
  logic [1:0]  m_bresp;
  logic        m_bvalid;
  logic        m_bready;
  logic [31:0] m_araddr;
  logic [7:0]  m_arlen;
  logic [2:0]  m_arsize;
  logic [1:0]  m_arburst;
  logic        m_arvalid;
  logic        m_arready;
  logic [63:0] m_rdata;
  logic [1:0]  m_rresp;
  logic        m_rvalid;
  logic        m_rready;

  always #4 clk = ~clk;

  wide_merge_bridge #(.BASE_ADDR(BASE)) dut (.*);

  // ---------------- downstream slave model ----------------
  int          aw_cnt, w_cnt, ar_cnt;
  logic [31:0] got_awaddr, got_araddr;
  logic [7:0]  got_awlen, got_arlen;
  logic [2:0]  got_awsize, got_arsize;
  logic [1:0]  got_awburst, got_arburst;
  logic [63:0] got_wdata;
  logic [7:0]  got_wstrb;
  logic        got_wlast;
  logic        sl_aw, sl_w, sl_rpend;
  logic [1:0]  cfg_bresp = 2'b00;
  logic [1:0]  cfg_rresp = 2'b00;
  logic [63:0] cfg_word  = 64'h0;
  logic        cfg_stall = 1'b0;

  assign m_awready = !cfg_stall;
  assign m_wready  = 1'b1;
  assign m_arready = !cfg_stall;

  always @(posedge clk) begin
    if (!rst_n) begin
      sl_aw <= 1'b0; sl_w <= 1'b0; sl_rpend <= 1'b0;
      m_bvalid <= 1'b0; m_rvalid <= 1'b0;
      m_bresp <= 2'b00; m_rresp <= 2'b00; m_rdata <= '0;
    end else begin
      if (m_awvalid && m_awready) begin
        aw_cnt <= aw_cnt + 1; sl_aw <= 1'b1;
        got_awaddr <= m_awaddr; got_awlen <= m_awlen;
        got_awsize <= m_awsize; got_awburst <= m_awburst;
      end
      if (m_wvalid && m_wready) begin
        w_cnt <= w_cnt + 1; sl_w <= 1'b1;
        got_wdata <= m_wdata; got_wstrb <= m_wstrb; got_wlast <= m_wlast;
      end
      if (sl_aw && sl_w && !m_bvalid) begin
        m_bvalid <= 1'b1; m_bresp <= cfg_bresp; sl_aw <= 1'b0; sl_w <= 1'b0;
      end
      if (m_bvalid && m_bready) m_bvalid <= 1'b0;
      if (m_arvalid && m_arready) begin
        ar_cnt <= ar_cnt + 1; sl_rpend <= 1'b1;
        got_araddr <= m_araddr; got_arlen <= m_arlen;
        got_arsize <= m_arsize; got_arburst <= m_arburst;
      end
      if (sl_rpend && !m_rvalid) begin
        m_rvalid <= 1'b1; m_rdata <= cfg_word; m_rresp <= cfg_rresp; sl_rpend <= 1'b0;
      end
      if (m_rvalid && m_rready) m_rvalid <= 1'b0;
    end
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic up_write(input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] sb, output logic [1:0] rsp);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = sb; s_awvalid = 1'b1; s_wvalid = 1'b1;
    #1;
    while (!s_awready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0; s_bready = 1'b1;
    #1;
    while (!s_bvalid) begin @(negedge clk); #1; end
    rsp = s_bresp;
    @(negedge clk);
    s_bready = 1'b0;
  endtask

  task automatic up_read(input logic [31:0] a, input int hold,
                         output logic [31:0] d, output logic [1:0] rsp);
    logic [31:0] d0;
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_arvalid = 1'b0;
    #1;
    while (!s_rvalid) begin @(negedge clk); #1; end
    d0 = s_rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk); #1;
      chk(s_rvalid && (s_rdata == d0), "R10", "read data held while not ready",
          {31'd0, s_rvalid, s_rdata}, {31'd0, 1'b1, d0});
    end
    s_rready = 1'b1;
    d = s_rdata; rsp = s_rresp;
    @(negedge clk);
    s_rready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    #1;
    chk(!s_bvalid && !s_rvalid && !m_awvalid && !m_wvalid && !m_arvalid, "R11",
        "valids low after reset",
        {59'd0, s_bvalid, s_rvalid, m_awvalid, m_wvalid, m_arvalid}, 64'd0);
  endtask

  task automatic t_write_pair();
    logic [1:0] r; int a0;
    a0 = aw_cnt;
    up_write(BASE, 32'h1122_3344, 4'hF, r);
    chk(r == 2'b00, "R1", "low write resp", r, 2'b00);
    chk(aw_cnt == a0, "R1", "low write downstream count", aw_cnt, a0);
    up_write(HIA, 32'hAABB_CCDD, 4'h3, r);
    chk(aw_cnt == a0 + 1 && w_cnt == a0 + 1, "R2", "one downstream write", aw_cnt, a0 + 1);
    chk(got_awaddr == BASE, "R2", "downstream write addr", got_awaddr, BASE);
    chk({got_awlen, got_awsize, got_awburst, got_wlast} == {8'd0, 3'd3, 2'b01, 1'b1}, "R2",
        "len/size/burst/last", {got_awlen, got_awsize, got_awburst, got_wlast},
        {8'd0, 3'd3, 2'b01, 1'b1});
    chk(got_wdata == 64'hAABB_CCDD_1122_3344, "R2", "merged data", got_wdata,
        64'hAABB_CCDD_1122_3344);
    chk(got_wstrb == 8'h3F, "R2", "merged strobes", got_wstrb, 8'h3F);
    chk(r == 2'b00, "R3", "high write resp okay", r, 2'b00);
  endtask

  task automatic t_bresp_pass();
    logic [1:0] r; int a0;
    cfg_bresp = 2'b10;
    up_write(BASE, 32'h5, 4'hF, r);
    up_write(HIA, 32'h6, 4'hF, r);
    chk(r == 2'b10, "R3", "downstream error passed up", r, 2'b10);
    cfg_bresp = 2'b00;
    a0 = aw_cnt;
    up_write(HIA, 32'h7, 4'hF, r);
    chk(r == 2'b10 && aw_cnt == a0, "R3", "low word consumed after pair", {r, aw_cnt[7:0]},
        {2'b10, a0[7:0]});
  endtask

  task automatic t_orphan_hi();
    logic [1:0] r; int a0;
    a0 = aw_cnt;
    up_write(HIA, 32'hDEAD_0001, 4'hF, r);
    chk(r == 2'b10, "R4", "orphan high write resp", r, 2'b10);
    chk(aw_cnt == a0, "R4", "orphan high write not forwarded", aw_cnt, a0);
  endtask

  task automatic t_replace();
    logic [1:0] r;
    up_write(BASE, 32'h0000_00A1, 4'h1, r);
    up_write(BASE, 32'h0000_00B2, 4'hC, r);
    up_write(HIA, 32'h0000_00C3, 4'h2, r);
    chk(got_wdata == 64'h0000_00C3_0000_00B2, "R5", "replaced low data", got_wdata,
        64'h0000_00C3_0000_00B2);
    chk(got_wstrb == 8'h2C, "R5", "replaced low strobes", got_wstrb, 8'h2C);
  endtask

  task automatic t_read_pair();
    logic [31:0] d; logic [1:0] r; int a0;
    cfg_word = 64'h0123_4567_89AB_CDEF;
    cfg_stall = 1'b1;
    fork
      begin repeat (3) @(negedge clk); cfg_stall = 1'b0; end
    join_none
    a0 = ar_cnt;
    up_read(BASE, 2, d, r);
    chk(d == 32'h89AB_CDEF && r == 2'b00, "R6", "low read data", {r, d}, {2'b00, 32'h89AB_CDEF});
    chk(ar_cnt == a0 + 1 && got_araddr == BASE, "R6", "one fetch at base", got_araddr, BASE);
    chk({got_arlen, got_arsize, got_arburst} == {8'd0, 3'd3, 2'b01}, "R6", "read len/size/burst",
        {got_arlen, got_arsize, got_arburst}, {8'd0, 3'd3, 2'b01});
    up_read(HIA, 1, d, r);
    chk(d == 32'h0123_4567 && r == 2'b00, "R7", "high read from hold", {r, d},
        {2'b00, 32'h0123_4567});
    chk(ar_cnt == a0 + 1, "R7", "high read not fetched", ar_cnt, a0 + 1);
    up_read(HIA, 0, d, r);
    chk(d == 32'h0 && r == 2'b10, "R8", "empty high read", {r, d}, {2'b10, 32'h0});
    chk(ar_cnt == a0 + 1, "R8", "empty high read not fetched", ar_cnt, a0 + 1);
  endtask

  task automatic t_rresp();
    logic [31:0] d; logic [1:0] r;
    cfg_rresp = 2'b10; cfg_word = 64'hFEED_0000_0000_BEEF;
    up_read(BASE, 0, d, r);
    chk(r == 2'b10 && d == 32'h0000_BEEF, "R6", "read error passed up", {r, d},
        {2'b10, 32'h0000_BEEF});
    cfg_rresp = 2'b00;
  endtask

  task automatic t_bad_addr();
    logic [31:0] d; logic [1:0] r; int a0, b0;
    a0 = aw_cnt; b0 = ar_cnt;
    up_write(BASE + 32'd8, 32'h1, 4'hF, r);
    chk(r == 2'b10 && aw_cnt == a0, "R12", "out-of-window write", {r, aw_cnt[7:0]},
        {2'b10, a0[7:0]});
    up_read(BASE + 32'd2, 0, d, r);
    chk(r == 2'b10 && d == 32'h0 && ar_cnt == b0, "R12", "misaligned read", {r, d},
        {2'b10, 32'h0});
  endtask

  task automatic t_priority();
    logic [31:0] d; logic [1:0] r;
    cfg_word = 64'h0000_0000_5A5A_5A5A;
    @(negedge clk);
    s_awaddr = BASE; s_wdata = 32'h9; s_wstrb = 4'hF; s_awvalid = 1'b1; s_wvalid = 1'b1;
    s_araddr = BASE; s_arvalid = 1'b1;
    #1;
    chk(s_awready && !s_arready, "R9", "write accepted before read", {s_awready, s_arready}, 2'b10);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0; s_bready = 1'b1;
    #1;
    chk(s_bvalid && !s_arready, "R9", "read held off during write", {s_bvalid, s_arready}, 2'b10);
    @(negedge clk);
    s_bready = 1'b0;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_arvalid = 1'b0;
    #1;
    while (!s_rvalid) begin @(negedge clk); #1; end
    d = s_rdata; r = s_rresp;
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
    chk(d == 32'h5A5A_5A5A && r == 2'b00, "R9", "read served after write", {r, d},
        {2'b00, 32'h5A5A_5A5A});
  endtask

  task automatic t_reset_clears();
    logic [31:0] d; logic [1:0] r; int a0;
    cfg_word = 64'h1111_2222_3333_4444;
    up_write(BASE, 32'h77, 4'hF, r);
    up_read(BASE, 0, d, r);
    do_reset();
    a0 = aw_cnt;
    up_write(HIA, 32'h88, 4'hF, r);
    chk(r == 2'b10 && aw_cnt == a0, "R11", "parked word cleared by reset", r, 2'b10);
    up_read(HIA, 0, d, r);
    chk(r == 2'b10 && d == 32'h0, "R11", "held half cleared by reset", {r, d}, {2'b10, 32'h0});
  endtask

  // ---------------- run ----------------
  initial begin
    aw_cnt = 0; w_cnt = 0; ar_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_write_pair();
    t_bresp_pass();
    t_orphan_hi();
    t_replace();
    t_read_pair();
    t_rresp();
    t_bad_addr();
    t_priority();
    t_reset_clears();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule